// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block decides who owns a shared memory word when two independent ports reach for it at once. Each port presents an enable, a write strobe and an address. A collision exists only when both ports are enabled on the same address. When that happens, one side keeps the location and the other side sees its busy flag driven low. The losing side's writes are held back. Its reads still complete, but they are marked busy.

Each port keeps a one-cycle history of its own request. That history tells the arbiter which side was already sitting on the address when the match appeared. The side that arrived earlier wins. When both arrive in the same cycle, the left side wins. Once ownership is decided, it holds until the collision ends, either because the addresses differ or because an enable drops.

A mode pin turns the block into a slave so that several devices can be stacked to build a wider word. In slave mode the busy flags are taken from a master device and not computed here. Each write is then qualified by the busy input of its own port.

Top module: `dpca_arbiter`

## Requirements
- R1: In master mode, when no collision exists, both busy outputs are high. The busy flags are active-low.
- R2: A collision is flagged only when both enables are 1 and the addresses are equal. An equal address with one port disabled drives no busy flag.
- R3: The port that held the same enable and address on the previous clock wins a new collision, and the other port's busy output goes low in the same cycle. Outside a tie, at most one busy output is low.
- R4: When neither port held its request on the previous clock, the left port wins.
- R5: While the collision continues from cycle to cycle, the winner stays the same, even if both ports move together to a new common address.
- R6: The busy flag returns high in the cycle in which the addresses differ or either enable is 0.
- R7: In master mode, a write-permit output is 1 only when its port is enabled, is writing (write strobe = 1), and is not the loser.
- R8: A read-permit output equals its port's enable AND NOT its write strobe, whatever the busy state.
- R9: In slave mode (mode pin = 0), each busy output copies the matching busy input, and local arbitration has no effect on it.
- R10: In slave mode, a write-permit output is 0 whenever its port's busy input is 0. When that busy input is 1, the write-permit output equals enable AND write.
- R11: Reset clears ownership and request history. The first collision after reset is treated as a tie, and during reset with idle ports both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (local arbitration), 0 = slave |
| lt_en | input | 1 | Left port enable |
| lt_wr | input | 1 | Left port write strobe (1 = write) |
| lt_addr | input | ADDR_W | Left port address |
| rt_en | input | 1 | Right port enable |
| rt_wr | input | 1 | Right port write strobe (1 = write) |
| rt_addr | input | ADDR_W | Right port address |
| lt_busy_in_n | input | 1 | Left busy from an external master (slave mode) |
| rt_busy_in_n | input | 1 | Right busy from an external master (slave mode) |
| lt_busy_n | output | 1 | Left busy flag, active-low |
| rt_busy_n | output | 1 | Right busy flag, active-low |
| lt_wr_ok | output | 1 | Left write permitted |
| rt_wr_ok | output | 1 | Right write permitted |
| lt_rd_ok | output | 1 | Left read proceeds |
| rt_rd_ok | output | 1 | Right read proceeds |

## Verification
The bench builds the block with ADDR_W = 4 and keeps the default left-wins tie setting. The narrow address makes it cheap to reach equal addresses, distinct ones, and a joint move to a fresh common address. The vector table runs back-to-back cycles, so each row's history decides the next row's arrival order. That covers left-first, right-first and same-cycle collisions, plus a stretch in slave mode. Directed steps then check reset with a request already held, which confirms that history is cleared.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.en   = en;
        hist_d.addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // request unchanged since last clock
    assign held = en && hist_q.en && (hist_q.addr == addr);
endmodule

// File: rtl/dpca_owner_fsm.sv
module dpca_owner_fsm
    import dpca_pkg::*;
#(
    parameter side_e TIE_WINNER = SIDE_LEFT
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   contend,
    input  logic   lt_held,
    input  logic   rt_held,
    output owner_e owner_now
);
    typedef struct packed {
        owner_e owner;
    } state_t;

    state_t st_d, st_q;
    owner_e tie_pick;

    generate
        if (TIE_WINNER == SIDE_LEFT) begin : g_tie_left
            assign tie_pick = OWN_LEFT;
        end else begin : g_tie_right
            assign tie_pick = OWN_RIGHT;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!contend) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            if (lt_held && !rt_held)      st_d.owner = OWN_LEFT;
            else if (rt_held && !lt_held) st_d.owner = OWN_RIGHT;
            else                          st_d.owner = tie_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE};
        else        st_q <= st_d;
    end

    assign owner_now = st_d.owner;
endmodule

// File: rtl/dpca_out_qual.sv
module dpca_out_qual
    import dpca_pkg::*;
(
    input  logic                 master_mode,
    input  owner_e               owner,
    input  logic [NUM_PORTS-1:0] en,
    input  logic [NUM_PORTS-1:0] wr,
    input  logic [NUM_PORTS-1:0] busy_in_n,
    output logic [NUM_PORTS-1:0] busy_n,
    output logic [NUM_PORTS-1:0] wr_ok,
    output logic [NUM_PORTS-1:0] rd_ok
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam owner_e RIVAL = (p == 0) ? OWN_RIGHT : OWN_LEFT;
        logic lose;
        logic blocked;

        assign lose     = (owner == RIVAL);
        assign busy_n[p] = master_mode ? !lose : busy_in_n[p];
        assign blocked  = !busy_n[p];
        assign wr_ok[p] = en[p] && wr[p] && !blocked;
        assign rd_ok[p] = en[p] && !wr[p];
    end
endmodule

// File: rtl/dpca_arbiter.sv
module dpca_arbiter
    import dpca_pkg::*;
#(
    parameter int    ADDR_W     = 12,
    parameter side_e TIE_WINNER = SIDE_LEFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lt_en,
    input  logic              lt_wr,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic              rt_wr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_busy_in_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_ok,
    output logic              rt_wr_ok,
    output logic              lt_rd_ok,
    output logic              rt_rd_ok
);
    logic [NUM_PORTS-1:0]             en_v, wr_v, bin_v, bout_v, wok_v, rok_v, held_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic                             contend;
    owner_e                           owner;

    assign en_v   = {rt_en, lt_en};
    assign wr_v   = {rt_wr, lt_wr};
    assign addr_v = {rt_addr, lt_addr};
    assign bin_v  = {rt_busy_in_n, lt_busy_in_n};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_trk
        dpca_port_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_v[p]),
            .addr (addr_v[p]),
            .held (held_v[p])
        );
    end

    assign contend = lt_en && rt_en && (lt_addr == rt_addr);

    dpca_owner_fsm #(.TIE_WINNER(TIE_WINNER)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .contend  (contend),
        .lt_held  (held_v[0]),
        .rt_held  (held_v[1]),
        .owner_now(owner)
    );

    dpca_out_qual u_qual (
        .master_mode(master_mode),
        .owner      (owner),
        .en         (en_v),
        .wr         (wr_v),
        .busy_in_n  (bin_v),
        .busy_n     (bout_v),
        .wr_ok      (wok_v),
        .rd_ok      (rok_v)
    );

    assign lt_busy_n = bout_v[0];
    assign rt_busy_n = bout_v[1];
    assign lt_wr_ok  = wok_v[0];
    assign rt_wr_ok  = wok_v[1];
    assign lt_rd_ok  = rok_v[0];
    assign rt_rd_ok  = rok_v[1];
endmodule

// File: rtl/dpca_arbiter_chk.sv
module dpca_arbiter_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              lt_en,
    input logic              lt_wr,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              rt_en,
    input logic              rt_wr,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              lt_busy_in_n,
    input logic              rt_busy_in_n,
    input logic              lt_busy_n,
    input logic              rt_busy_n,
    input logic              lt_wr_ok,
    input logic              rt_wr_ok,
    input logic              lt_rd_ok,
    input logic              rt_rd_ok
);
    logic clash;
    logic armed_q;

    assign clash = lt_en && rt_en && (lt_addr == rt_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !clash) |-> (lt_busy_n && rt_busy_n));

    p_one_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash) |-> (lt_busy_n != rt_busy_n));

    p_first_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && master_mode && clash && !$past(clash)
         && $past(rt_en) && ($past(rt_addr) == rt_addr)
         && !($past(lt_en) && ($past(lt_addr) == lt_addr))) |-> !lt_busy_n);

    p_hold_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && master_mode && clash
         && $past(master_mode && clash && !lt_busy_n)) |-> !lt_busy_n);

    p_hold_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && master_mode && clash
         && $past(master_mode && clash && !rt_busy_n)) |-> !rt_busy_n);

    p_loser_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && (!lt_busy_n || !rt_busy_n))
        |-> (!(lt_wr_ok && !lt_busy_n) && !(rt_wr_ok && !rt_busy_n)));

    p_read_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_rd_ok == (lt_en && !lt_wr)) && (rt_rd_ok == (rt_en && !rt_wr)));

    p_slave_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (lt_busy_n == lt_busy_in_n && rt_busy_n == rt_busy_in_n));

    p_slave_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && (!lt_busy_in_n || !rt_busy_in_n))
        |-> (!(lt_wr_ok && !lt_busy_in_n) && !(rt_wr_ok && !rt_busy_in_n)));
endmodule

bind dpca_arbiter dpca_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpca_arbiter_bench.sv
module dpca_arbiter_bench;
    localparam int AW = 4;
    localparam int NV = 15;

    typedef struct packed {
        bit          m;
        bit          le;
        bit          lw;
        bit [AW-1:0] la;
        bit          re;
        bit          rw;
        bit [AW-1:0] ra;
        bit          bil;
        bit          bir;
        bit [5:0]    exp;   // {lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok, lt_rd_ok, rt_rd_ok}
        int          req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1,1'b0,4'd3,  1'b0,1'b0,4'd3,  1'b1,1'b1, 6'b110010, 2},  // R2 one side off
        '{1'b1, 1'b1,1'b0,4'd3,  1'b1,1'b1,4'd3,  1'b1,1'b1, 6'b100010, 3},  // R3 left was first
        '{1'b1, 1'b1,1'b0,4'd3,  1'b1,1'b1,4'd3,  1'b1,1'b1, 6'b100010, 5},  // R5 held
        '{1'b1, 1'b1,1'b1,4'd3,  1'b1,1'b1,4'd3,  1'b1,1'b1, 6'b101000, 7},  // R7 loser blocked
        '{1'b1, 1'b1,1'b1,4'd3,  1'b1,1'b1,4'd5,  1'b1,1'b1, 6'b111100, 6},  // R6 address moves
        '{1'b1, 1'b1,1'b0,4'd3,  1'b1,1'b0,4'd3,  1'b1,1'b1, 6'b100011, 8},  // R8 loser read
        '{1'b1, 1'b0,1'b0,4'd3,  1'b1,1'b0,4'd3,  1'b1,1'b1, 6'b110001, 6},  // R6 enable drops
        '{1'b1, 1'b1,1'b1,4'd3,  1'b1,1'b0,4'd3,  1'b1,1'b1, 6'b010001, 3},  // R3 right was first
        '{1'b1, 1'b1,1'b0,4'd9,  1'b1,1'b0,4'd9,  1'b1,1'b1, 6'b010011, 5},  // R5 joint move
        '{1'b1, 1'b1,1'b0,4'd10, 1'b1,1'b0,4'd11, 1'b1,1'b1, 6'b110011, 1},  // R1 no clash
        '{1'b1, 1'b1,1'b1,4'd12, 1'b1,1'b1,4'd12, 1'b1,1'b1, 6'b101000, 4},  // R4 tie
        '{1'b0, 1'b1,1'b1,4'd12, 1'b1,1'b1,4'd12, 1'b0,1'b1, 6'b010100, 10}, // R10 and R9
        '{1'b0, 1'b1,1'b1,4'd12, 1'b1,1'b1,4'd12, 1'b1,1'b1, 6'b111100, 9},  // R9 local ignored
        '{1'b0, 1'b1,1'b1,4'd12, 1'b1,1'b1,4'd12, 1'b1,1'b0, 6'b101000, 10}, // R10
        '{1'b1, 1'b1,1'b1,4'd1,  1'b1,1'b1,4'd2,  1'b1,1'b1, 6'b111100, 1}   // R1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          lt_en = 1'b0, lt_wr = 1'b0, rt_en = 1'b0, rt_wr = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic          lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic          lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok, lt_rd_ok, rt_rd_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dpca_arbiter #(.ADDR_W(AW)) u_dpca_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .lt_en(lt_en), .lt_wr(lt_wr), .lt_addr(lt_addr),
        .rt_en(rt_en), .rt_wr(rt_wr), .rt_addr(rt_addr),
        .lt_busy_in_n(lt_busy_in_n), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
        .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok),
        .lt_rd_ok(lt_rd_ok), .rt_rd_ok(rt_rd_ok)
    );

    task automatic compare(input logic [5:0] exp, input int req, input int idx);
        logic [5:0] got;
        got = {lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok, lt_rd_ok, rt_rd_ok};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: actual %b expected %b", req, idx, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        master_mode  = v.m;
        lt_en = v.le; lt_wr = v.lw; lt_addr = v.la;
        rt_en = v.re; rt_wr = v.rw; rt_addr = v.ra;
        lt_busy_in_n = v.bil; rt_busy_in_n = v.bir;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        compare(6'b110000, 11, -1);        // R11 idle in reset
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            #5;
            compare(TBL[i].exp, TBL[i].req, i);
            @(negedge clk);
        end
        // R11: right holds a request across reset; history must be cleared
        apply('{1'b1, 1'b0,1'b0,4'd5, 1'b1,1'b0,4'd5, 1'b1,1'b1, 6'b110001, 11});
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        compare(6'b110001, 11, 100);
        @(negedge clk);
        rst_n = 1'b1;
        lt_en = 1'b1; lt_wr = 1'b1;
        #5;
        compare(6'b101001, 11, 101);       // R11 treated as tie: left wins
        @(negedge clk);
        // R6 release by right enable drop after the hold
        rt_en = 1'b0;
        #5;
        compare(6'b111000, 6, 102);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule